// File: doc/BRIEF.md
# Burst Write Master Adapter

This block takes simple internal write commands (a start address and a beat count) together with a separate stream of write beats, and turns them into AXI4 write bursts. It drives the AW, W and B channels of an AXI4 master port. Commands wait in a request queue whose depth is a latency parameter. Write beats wait in a data buffer sized for the outstanding limit times the longest burst.

A burst is started on AW only when three things hold. Every beat of the burst must already be in the data buffer. The previous burst's W beats must be finished. Fewer bursts than the outstanding limit may be waiting for a write response. The response tracker is a two-bit tag queue one entry shorter than the outstanding limit, placed behind a single head slot. It returns each B response to the internal side together with the tag of the burst it closes.

Top module: `axi_burst_writer`

## Requirements
- R1: The request queue holds LATENCY commands; `cmd_ready` is low exactly when it is full, and a command is taken on a cycle with `cmd_valid` and `cmd_ready` both high.
- R2: `m_awaddr` carries the command's address unchanged, with an address width of 64 bits when ADDR64 is 1 and 32 bits when it is 0.
- R3: At most MAX_OUT bursts are between their AW issue and their B handshake. While no B response completes, exactly MAX_OUT bursts are issued and further AW requests are held back.
- R4: No AW request for a burst appears until all of that burst's beats are in the data buffer.
- R5: `m_awlen` equals the command length minus one, `m_awsize` equals log2 of the data bytes per beat, and `m_awburst` is 2'b01 (incrementing).
- R6: W beats leave in the order they were pushed, with every `m_wstrb` bit set. `m_wlast` is high only on beat number length-1 (counted from 0) of each burst.
- R7: The data buffer holds MAX_OUT*MAX_BURST beats; `data_ready` is low exactly when it is full.
- R8: One cycle after each B handshake, `ack_valid` is high for one cycle with `ack_resp` equal to the BRESP bits and `ack_tag` equal to the burst's issue number modulo 4 (the first burst after reset is 0). `ack_valid` is low in all other cycles.
- R9: While `m_awvalid` or `m_wvalid` is high and its ready is low, the valid stays high and the channel's payload stays unchanged.
- R10: While `rst` is high, `m_awvalid`, `m_wvalid`, `m_bready` and `ack_valid` are low and `cmd_ready` and `data_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Request queue has room |
| cmd_addr | input | ADDR_W | Burst start address |
| cmd_len | input | LEN_W | Beats in the burst, 1..MAX_BURST |
| data_valid | input | 1 | Write beat offered |
| data_ready | output | 1 | Data buffer has room |
| data_in | input | DATA_W | Write beat |
| ack_valid | output | 1 | Write response returned |
| ack_resp | output | 2 | BRESP of the returned response |
| ack_tag | output | 2 | Issue number of the burst, modulo 4 |
| m_awvalid | output | 1 | AW valid |
| m_awready | input | 1 | AW ready |
| m_awaddr | output | ADDR_W | AW address |
| m_awlen | output | 8 | AW beats minus one |
| m_awsize | output | 3 | AW beat size code |
| m_awburst | output | 2 | AW burst type |
| m_wvalid | output | 1 | W valid |
| m_wready | input | 1 | W ready |
| m_wdata | output | DATA_W | W data |
| m_wstrb | output | DATA_W/8 | W byte strobes |
| m_wlast | output | 1 | Final beat of a burst |
| m_bvalid | input | 1 | B valid |
| m_bready | output | 1 | B ready |
| m_bresp | input | 2 | B response code |

## Verification
An AW request becomes visible one cycle after the issue decision, and no earlier than one cycle after the last beat of its burst enters the buffer. `cmd_ready` and `data_ready` change one cycle after the push that fills their queue. The acknowledge is due exactly one cycle after the B handshake edge. The bench decides every handshake at the falling edge from values that stay stable until the next rising edge. It then checks the acknowledge at the following falling edge and reads the full flags at the falling edge after the filling push. All AW and W payloads are checked at their handshakes against queues of expected values, and the memory is compared against an arithmetic pattern at the end.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  localparam logic [1:0] AXI_BURST_INCR = 2'b01;
  localparam int TAG_W = 2;

  function automatic int axsize_of(input int data_w);
    return $clog2(data_w / 8);
  endfunction
endpackage

// File: rtl/wbm_fifo.sv
module wbm_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [WIDTH-1:0]             wr_data,
  output logic                         full,
  input  logic                         rd_en,
  output logic [WIDTH-1:0]             rd_data,
  output logic                         rd_valid,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    mcount;
  logic             out_valid;
  logic [WIDTH-1:0] dout;
  logic             load;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign load     = (mcount != '0) && (!out_valid || rd_en);
  assign count    = mcount + CW'(out_valid);
  assign full     = (count == CW'(DEPTH));
  assign rd_valid = out_valid;
  assign rd_data  = dout;

  // storage and prefetch register, no reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
    if (load)  dout      <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      mcount    <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr_en) wptr <= bump(wptr);
      if (load)  rptr <= bump(rptr);
      mcount <= mcount + CW'(wr_en) - CW'(load);
      if (load)       out_valid <= 1'b1;
      else if (rd_en) out_valid <= 1'b0;
    end
  end

  // R1, R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/wbm_resp_tracker.sv
module wbm_resp_tracker #(
  parameter int MAX_OUT = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          issue,
  input  logic [wbm_pkg::TAG_W-1:0]     issue_tag,
  output logic                          room,
  input  logic                          b_fire,
  output logic                          head_valid,
  output logic [wbm_pkg::TAG_W-1:0]     head_tag,
  output logic [$clog2(MAX_OUT+1)-1:0]  inflight
);
  localparam int QD = MAX_OUT - 1;
  localparam int QCW = $clog2(QD + 1);
  localparam int IW = $clog2(MAX_OUT + 1);

  logic                        slot_valid;
  logic [wbm_pkg::TAG_W-1:0]   slot_tag;
  logic                        q_wr, q_rd, q_full, q_valid;
  logic [wbm_pkg::TAG_W-1:0]   q_data;
  logic [QCW-1:0]              q_count;
  logic                        slot_free, refill, direct;

  assign slot_free = !slot_valid || b_fire;
  assign refill    = slot_free && q_valid;
  assign direct    = issue && slot_free && (q_count == '0);
  assign q_wr      = issue && !direct;
  assign q_rd      = refill;

  wbm_fifo #(.WIDTH(wbm_pkg::TAG_W), .DEPTH(QD)) u_tagq (
    .clk(clk), .rst(rst),
    .wr_en(q_wr), .wr_data(issue_tag), .full(q_full),
    .rd_en(q_rd), .rd_data(q_data), .rd_valid(q_valid), .count(q_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_valid <= 1'b0;
      slot_tag   <= '0;
    end else begin
      if (refill) begin
        slot_valid <= 1'b1;
        slot_tag   <= q_data;
      end else if (direct) begin
        slot_valid <= 1'b1;
        slot_tag   <= issue_tag;
      end else if (b_fire) begin
        slot_valid <= 1'b0;
      end
    end
  end

  assign inflight   = IW'(slot_valid) + IW'(q_count);
  assign room       = (inflight < IW'(MAX_OUT)) && !q_full;
  assign head_valid = slot_valid;
  assign head_tag   = slot_tag;

  // R3
  inflight_cap_chk: assert property (@(posedge clk) disable iff (rst)
    inflight <= IW'(MAX_OUT));
endmodule

// File: rtl/axi_burst_writer.sv
module axi_burst_writer #(
  parameter int ADDR64    = 1,
  parameter int DATA_W    = 64,
  parameter int MAX_BURST = 16,
  parameter int MAX_OUT   = 4,
  parameter int LATENCY   = 8,
  localparam int ADDR_W   = (ADDR64 != 0) ? 64 : 32,
  localparam int LEN_W    = $clog2(MAX_BURST + 1),
  localparam int STRB_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              data_valid,
  output logic              data_ready,
  input  logic [DATA_W-1:0] data_in,
  output logic              ack_valid,
  output logic [1:0]        ack_resp,
  output logic [1:0]        ack_tag,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic [2:0]        m_awsize,
  output logic [1:0]        m_awburst,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [STRB_W-1:0] m_wstrb,
  output logic              m_wlast,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [1:0]        m_bresp
);
  localparam int REQ_W   = ADDR_W + LEN_W;
  localparam int BUF_D   = MAX_OUT * MAX_BURST;
  localparam int BUF_CW  = $clog2(BUF_D + 1);
  localparam int REQ_CW  = $clog2(LATENCY + 1);
  localparam int IW      = $clog2(MAX_OUT + 1);

  // request queue
  logic              req_full, req_valid, req_pop;
  logic [REQ_W-1:0]  req_head;
  logic [REQ_CW-1:0] req_count;
  logic [ADDR_W-1:0] head_addr;
  logic [LEN_W-1:0]  head_len;

  wbm_fifo #(.WIDTH(REQ_W), .DEPTH(LATENCY)) u_reqq (
    .clk(clk), .rst(rst),
    .wr_en(cmd_valid && !req_full), .wr_data({cmd_addr, cmd_len}), .full(req_full),
    .rd_en(req_pop), .rd_data(req_head), .rd_valid(req_valid), .count(req_count)
  );
  assign cmd_ready = !req_full;
  assign {head_addr, head_len} = req_head;

  // data buffer
  logic              dbuf_full, d_valid, w_fire;
  logic [DATA_W-1:0] d_data;
  logic [BUF_CW-1:0] dbuf_count;

  wbm_fifo #(.WIDTH(DATA_W), .DEPTH(BUF_D)) u_dbuf (
    .clk(clk), .rst(rst),
    .wr_en(data_valid && !dbuf_full), .wr_data(data_in), .full(dbuf_full),
    .rd_en(w_fire), .rd_data(d_data), .rd_valid(d_valid), .count(dbuf_count)
  );
  assign data_ready = !dbuf_full;

  // response tracker
  logic                      room, b_fire, head_valid, issue;
  logic [wbm_pkg::TAG_W-1:0] head_tag, tag_ctr;
  logic [IW-1:0]             inflight;

  wbm_resp_tracker #(.MAX_OUT(MAX_OUT)) u_track (
    .clk(clk), .rst(rst),
    .issue(issue), .issue_tag(tag_ctr), .room(room),
    .b_fire(b_fire), .head_valid(head_valid), .head_tag(head_tag),
    .inflight(inflight)
  );

  // issue and W sequencing
  logic             aw_pend;
  logic [LEN_W-1:0] w_left;

  assign issue   = req_valid && !aw_pend && (w_left == '0) &&
                   (dbuf_count >= BUF_CW'(head_len)) && room;
  assign req_pop = issue;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_pend  <= 1'b0;
      m_awaddr <= '0;
      m_awlen  <= '0;
      w_left   <= '0;
      tag_ctr  <= '0;
    end else begin
      if (issue) begin
        aw_pend  <= 1'b1;
        m_awaddr <= head_addr;
        m_awlen  <= 8'(head_len - LEN_W'(1));
        w_left   <= head_len;
        tag_ctr  <= tag_ctr + 1'b1;
      end else begin
        if (m_awready) aw_pend <= 1'b0;
        if (w_fire)    w_left  <= w_left - LEN_W'(1);
      end
    end
  end

  assign m_awvalid = aw_pend;
  assign m_awsize  = 3'(wbm_pkg::axsize_of(DATA_W));
  assign m_awburst = wbm_pkg::AXI_BURST_INCR;
  assign m_wvalid  = (w_left != '0) && d_valid;
  assign w_fire    = m_wvalid && m_wready;
  assign m_wdata   = d_data;
  assign m_wstrb   = '1;
  assign m_wlast   = (w_left == LEN_W'(1));

  // write acknowledge
  assign m_bready = head_valid;
  assign b_fire   = m_bvalid && m_bready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid <= 1'b0;
      ack_resp  <= '0;
      ack_tag   <= '0;
    end else begin
      ack_valid <= b_fire;
      ack_resp  <= m_bresp;
      ack_tag   <= head_tag;
    end
  end

  // R1
  req_depth_chk: assert property (@(posedge clk) disable iff (rst)
    req_count <= REQ_CW'(LATENCY));

  // R4
  burst_buffered_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(m_awvalid) |-> (int'(dbuf_count) > int'(m_awlen)));

  // R9
  aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr) && $stable(m_awlen)));

  // R9
  w_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wlast)));

  // R8
  ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (m_bvalid && m_bready) |=> (ack_valid && ack_resp == $past(m_bresp)));

  // R3
  bready_owner_chk: assert property (@(posedge clk) disable iff (rst)
    m_bready |-> (inflight != '0));
endmodule

// File: tb/axi_burst_writer_test.sv
`timescale 1ns/1ps
module axi_burst_writer_test;
  localparam int AWD = 32;
  localparam int DW  = 32;
  localparam int LW  = 3;
  localparam int NOUT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          cmd_valid = 0, cmd_ready;
  logic [AWD-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic          data_valid = 0, data_ready;
  logic [DW-1:0] data_in = '0;
  logic          ack_valid;
  logic [1:0]    ack_resp, ack_tag;
  logic          m_awvalid, m_awready = 0;
  logic [AWD-1:0] m_awaddr;
  logic [7:0]    m_awlen;
  logic [2:0]    m_awsize;
  logic [1:0]    m_awburst;
  logic          m_wvalid, m_wready = 0;
  logic [DW-1:0] m_wdata;
  logic [3:0]    m_wstrb;
  logic          m_wlast;
  logic          m_bvalid = 0, m_bready;
  logic [1:0]    m_bresp = '0;

  axi_burst_writer #(.ADDR64(0), .DATA_W(DW), .MAX_BURST(4), .MAX_OUT(NOUT), .LATENCY(4)) uut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .data_valid(data_valid), .data_ready(data_ready), .data_in(data_in),
    .ack_valid(ack_valid), .ack_resp(ack_resp), .ack_tag(ack_tag),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
    .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] addr_of(input int id);
    return 32'h1000 + 32'(id) * 32'd16;
  endfunction

  function automatic logic [31:0] pattern(input int id, input int beat);
    return 32'h5A00_0000 + 32'(id) * 32'h0001_0101 + 32'(beat) * 32'd7;
  endfunction

  // expectation and slave state
  logic [31:0] exp_addr_q[$];
  int          exp_len_q[$];
  logic [31:0] s_aw_addr[$];
  int          s_aw_len[$];
  logic [31:0] s_w_data[$];
  bit          s_w_last[$];
  logic [3:0]  s_w_strb[$];
  logic [31:0] mem [256];
  int burst_len [64];
  int beat_idx = 0, b_pend = 0, in_flight = 0, max_in_flight = 0;
  int aw_count = 0, ack_count = 0, b_sent = 0, n_bursts = 0;
  bit b_hold = 0, b_fire_prev = 0, aw_wait = 0, w_wait = 0;
  logic [1:0]  cur_bresp = '0;
  logic [31:0] aw_prev_addr = '0, w_prev_data = '0;

  always @(negedge clk) begin
    if (!rst) begin
      // R8: acknowledge one cycle after the B handshake
      if (ack_valid != b_fire_prev)
        check(1'b0, "R8", "ack_valid timing", ack_valid, b_fire_prev);
      if (b_fire_prev) begin
        check(ack_resp == cur_bresp, "R8", "ack_resp", ack_resp, cur_bresp);
        check(ack_tag == 2'(ack_count), "R8", "ack_tag", ack_tag, 2'(ack_count));
        ack_count++;
        in_flight--;
        b_pend--;
        m_bvalid = 1'b0;
      end
      // R9: payload held while waiting
      if (aw_wait)
        check(m_awvalid && m_awaddr == aw_prev_addr, "R9", "aw hold", m_awaddr, aw_prev_addr);
      if (w_wait)
        check(m_wvalid && m_wdata == w_prev_data, "R9", "w hold", m_wdata, w_prev_data);
      // AW channel
      m_awready = ($urandom_range(0, 3) != 0);
      if (m_awvalid && m_awready) begin
        logic [31:0] ea;
        int el;
        ea = exp_addr_q.pop_front();
        el = exp_len_q.pop_front();
        check(m_awaddr == ea, "R2", "awaddr", m_awaddr, ea);
        check(m_awlen == 8'(el - 1), "R5", "awlen", m_awlen, el - 1);
        check(m_awsize == 3'd2, "R5", "awsize", m_awsize, 2);
        check(m_awburst == 2'b01, "R5", "awburst", m_awburst, 1);
        s_aw_addr.push_back(m_awaddr);
        s_aw_len.push_back(el);
        aw_count++;
        in_flight++;
        if (in_flight > max_in_flight) max_in_flight = in_flight;
        check(in_flight <= NOUT, "R3", "in-flight bound", in_flight, NOUT);
      end
      aw_wait = m_awvalid && !m_awready;
      aw_prev_addr = m_awaddr;
      // W channel
      m_wready = ($urandom_range(0, 3) != 0);
      if (m_wvalid && m_wready) begin
        s_w_data.push_back(m_wdata);
        s_w_last.push_back(m_wlast);
        s_w_strb.push_back(m_wstrb);
      end
      w_wait = m_wvalid && !m_wready;
      w_prev_data = m_wdata;
      // join address and beats into memory
      while (s_aw_len.size() > 0 && s_w_data.size() > 0) begin
        logic [31:0] d;
        bit lst;
        logic [3:0] st;
        int idx;
        d = s_w_data.pop_front();
        lst = s_w_last.pop_front();
        st = s_w_strb.pop_front();
        idx = int'((s_aw_addr[0] - 32'h1000) >> 2) + beat_idx;
        if (idx >= 0 && idx < 256) mem[idx] = d;
        check(st == 4'hF, "R6", "wstrb", st, 4'hF);
        check(lst == (beat_idx == s_aw_len[0] - 1), "R6", "wlast", lst, beat_idx == s_aw_len[0] - 1);
        if (beat_idx == s_aw_len[0] - 1) begin
          void'(s_aw_addr.pop_front());
          void'(s_aw_len.pop_front());
          beat_idx = 0;
          b_pend++;
        end else begin
          beat_idx++;
        end
      end
      // B channel
      if (!m_bvalid && b_pend > 0 && !b_hold && $urandom_range(0, 2) != 0) begin
        m_bvalid = 1'b1;
        cur_bresp = (b_sent % 5 == 3) ? 2'b10 : ((b_sent % 7 == 5) ? 2'b01 : 2'b00);
        m_bresp = cur_bresp;
        b_sent++;
      end
      b_fire_prev = m_bvalid && m_bready;
    end
  end

  task automatic push_cmd(input int id, input int len);
    exp_addr_q.push_back(addr_of(id));
    exp_len_q.push_back(len);
    burst_len[id] = len;
    cmd_valid = 1'b1;
    cmd_addr = addr_of(id);
    cmd_len = LW'(len);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic push_beat(input int id, input int beat);
    data_valid = 1'b1;
    data_in = pattern(id, beat);
    while (!data_ready) @(negedge clk);
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic push_burst(input int id, input int len);
    push_cmd(id, len);
    for (int b = 0; b < len; b++) push_beat(id, b);
  endtask

  task automatic wait_idle();
    while (ack_count < n_bursts) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d acks", ack_count, n_bursts);
    finish_run();
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (4) @(negedge clk);
    // R10: reset state
    check(!m_awvalid, "R10", "awvalid in reset", m_awvalid, 0);
    check(!m_wvalid, "R10", "wvalid in reset", m_wvalid, 0);
    check(!m_bready, "R10", "bready in reset", m_bready, 0);
    check(!ack_valid, "R10", "ack_valid in reset", ack_valid, 0);
    check(cmd_ready, "R10", "cmd_ready in reset", cmd_ready, 1);
    check(data_ready, "R10", "data_ready in reset", data_ready, 1);
    rst = 1'b0;
    @(negedge clk);

    // sweep over every burst length under random backpressure
    for (int len = 1; len <= 4; len++) begin
      for (int rep = 0; rep < 6; rep++) begin
        push_burst(n_bursts, len);
        n_bursts++;
      end
    end
    wait_idle();

    // R4: a partly buffered burst is not started
    push_cmd(24, 4);
    for (int b = 0; b < 3; b++) push_beat(24, b);
    repeat (20) @(negedge clk);
    check(!m_awvalid && aw_count == 24, "R4", "aw before full burst", aw_count, 24);
    check(!m_wvalid, "R4", "w before full burst", m_wvalid, 0);
    push_beat(24, 3);
    n_bursts = 25;
    wait_idle();

    // R3: withheld responses cap the bursts in flight
    b_hold = 1'b1;
    for (int id = 25; id < 28; id++) push_burst(id, 2);
    repeat (40) @(negedge clk);
    check(in_flight == NOUT, "R3", "in flight at cap", in_flight, NOUT);
    check(aw_count == 28, "R3", "aw count at cap", aw_count, 28);
    // R7: data buffer capacity
    for (int id = 28; id < 32; id++)
      for (int b = 0; b < 3; b++) push_beat(id, b);
    check(!data_ready, "R7", "data_ready when full", data_ready, 0);
    // R1: request queue capacity
    for (int id = 28; id < 32; id++) push_cmd(id, 3);
    check(!cmd_ready, "R1", "cmd_ready when full", cmd_ready, 0);
    check(!m_awvalid && aw_count == 28, "R3", "no issue past cap", aw_count, 28);
    b_hold = 1'b0;
    n_bursts = 32;
    wait_idle();
    check(max_in_flight == NOUT, "R3", "peak in flight", max_in_flight, NOUT);
    check(cmd_ready && data_ready, "R1", "queues drained", {cmd_ready, data_ready}, 3);

    // R6: memory content, beats in order
    for (int id = 0; id < 32; id++)
      for (int b = 0; b < burst_len[id]; b++)
        check(mem[id * 4 + b] == pattern(id, b), "R6", "memory word", mem[id * 4 + b], pattern(id, b));
    finish_run();
  end
endmodule